// File: doc/BRIEF.md
# Deferred-Fault Register File

This block is the architectural register file plus the writeback and exception-check stage of a machine whose compiler hoists instructions above branches. Every register holds a data word and a one-bit fault tag. When a hoisted (speculative) instruction faults, no trap is taken. Instead the destination is tagged and its data field receives the faulting instruction's PC. Speculative consumers of a tagged register pass the tag and the stored PC on to their own destination.

The deferred fault becomes a precise trap only when a non-speculative instruction reads a tagged register. That instruction acts as the sentinel, and the trap reports the PC of the instruction that originally faulted. A non-speculative instruction that faults on clean sources traps at once with its own PC. An explicit check is a non-speculative instruction that reads one register and writes nothing.

Each issue presents the following:
- a valid strobe and a speculative bit;
- an operation class;
- two source indices, each with a use bit;
- a destination index with a write enable;
- its PC, its result and the fault signal from the execution unit.

The two read ports are combinational on the source indices and feed the datapath.

Top module: `dfr_top`

## Requirements
- R1: After synchronous active-low reset, every register reads data 0 with its tag clear, and trap_valid is low.
- R2: Register 0 always reads data 0 with its tag clear, whatever is written to it.
- R3: A speculative instruction with no tagged used source and no fault writes its result into rd and clears the tag of rd.
- R4: A speculative instruction with no tagged used source that faults sets the tag of rd and writes its own PC into rd. It raises no trap.
- R5: A speculative instruction with a tagged used source sets the tag of rd and copies that source's data (the stored faulting PC) into rd. It raises no trap.
- R6: A non-speculative instruction with no tagged used source that faults raises a trap reporting its own PC, and rd is left unchanged.
- R7: A non-speculative instruction with a tagged used source raises a trap reporting that source's data field, and rd is left unchanged.
- R8: The operation class is encoded 0 = plain ALU, 1 = memory, 2 = divide and 3 = floating point. The fault input may only be asserted for classes 1 to 3, and a fault behaves the same in each of these classes.
- R9: When both used sources are tagged, the data of source 1 is the PC that is propagated or reported.
- R10: A trap appears as trap_valid high for exactly the one cycle after the issuing edge, with trap_pc valid in that cycle.
- R11: An explicit check (non-speculative, write enable low, one used source) traps if and only if that source is tagged, and it writes no register.
- R12: A source whose use bit is low has no effect, even when its register is tagged.
- R13: A non-speculative instruction with no tagged used source and no fault writes its result into rd and clears the tag of rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction completes this cycle |
| iss_spec | input | 1 | Instruction was hoisted (speculative) |
| iss_class | input | 2 | Operation class (R8 encoding) |
| iss_rs1 | input | 5 | Source 1 index; also read port 1 address |
| iss_use1 | input | 1 | Source 1 is read by the instruction |
| iss_rs2 | input | 5 | Source 2 index; also read port 2 address |
| iss_use2 | input | 1 | Source 2 is read by the instruction |
| iss_rd | input | 5 | Destination index |
| iss_wen | input | 1 | Instruction has a destination |
| iss_pc | input | 32 | PC of the instruction |
| iss_result | input | 32 | Result from the execution unit |
| iss_fault | input | 1 | Execution unit detected a fault |
| rd1_data | output | 32 | Read port 1 data |
| rd1_tag | output | 1 | Read port 1 fault tag |
| rd2_data | output | 32 | Read port 2 data |
| rd2_tag | output | 1 | Read port 2 fault tag |
| trap_valid | output | 1 | Precise exception raised (one cycle) |
| trap_pc | output | 32 | PC reported with the exception |

## Verification
A wrong tag or wrong stored PC in a register stays invisible until something reads it. It then shows up in one of two places: the read ports, in the cycle after the faulty write, or trap_pc, one cycle after a non-speculative consumer issues. The bench therefore reads back every register it touches right after the instruction that touched it. It also drives sentinels and checks through propagation chains, so that a PC corrupted along a chain shows up in a reported trap. Missing or spurious traps are caught by comparing each trap_valid pulse against a queue of expected traps, and by requiring that queue to be empty at the end.

// File: rtl/dfr_pkg.sv
// Package: shared types for the deferred-fault register file.
// Assumes the data width is at least the PC width, since the data
// field doubles as storage for a faulting PC.
package dfr_pkg;
    typedef enum logic [1:0] {
        OPC_ALU  = 2'd0,
        OPC_MEM  = 2'd1,
        OPC_DIV  = 2'd2,
        OPC_FPU  = 2'd3
    } op_class_e;
endpackage

// File: rtl/dfr_storage.sv
// Module: dfr_storage
// Register array with two combinational read ports and one write port.
// Each entry holds a data word and a fault tag. Entry 0 is never
// written and always reads zero with its tag clear.
// Assumes a single write per cycle; reads return the pre-write contents.
module dfr_storage #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_tag,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic              ra_tag,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_tag
);
    logic [DATA_W-1:0] data_q [NREG];
    logic [NREG-1:0]   tag_q;

    // Entry 0 is a constant; entries 1..NREG-1 are real storage.
    assign data_q[0] = '0;
    assign tag_q[0]  = 1'b0;

    generate
        for (genvar g = 1; g < NREG; g++) begin : g_entry
            // Purpose: reset or update one register entry.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q[g] <= '0;
                    tag_q[g]  <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    data_q[g] <= wr_data;
                    tag_q[g]  <= wr_tag;
                end
            end
        end
    endgenerate

    // Purpose: combinational read of both ports.
    always_comb begin
        ra_data = data_q[ra_idx];
        ra_tag  = tag_q[ra_idx];
        rb_data = data_q[rb_idx];
        rb_tag  = tag_q[rb_idx];
    end

    AST_R0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == '0) |-> (ra_data == '0 && !ra_tag)); // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && ra_idx == wr_idx) |=>
        ($past(ra_idx) != ra_idx) || (ra_data == $past(wr_data) && ra_tag == $past(wr_tag))); // R3
endmodule

// File: rtl/dfr_resolve.sv
// Module: dfr_resolve
// Combinational decision for one completing instruction. It chooses
// between a normal write, a deferred tag write and a precise trap,
// and selects the PC to store or report.
// Assumes the source values come from dfr_storage for the same
// indices; unused sources are masked here.
module dfr_resolve #(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  logic              spec,
    input  logic              use1,
    input  logic              use2,
    input  logic              wen,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] result,
    input  logic              fault,
    input  logic [DATA_W-1:0] s1_data,
    input  logic              s1_tag,
    input  logic [DATA_W-1:0] s2_data,
    input  logic              s2_tag,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_tag,
    output logic              trap,
    output logic [DATA_W-1:0] trap_pc
);
    logic              hit1, hit2, src_hit;
    logic [DATA_W-1:0] src_pc;

    // Purpose: find a tagged used source, with source 1 taking priority.
    always_comb begin
        hit1    = use1 && s1_tag;
        hit2    = use2 && s2_tag;
        src_hit = hit1 || hit2;
        src_pc  = hit1 ? s1_data : s2_data;
    end

    // Purpose: apply the exception model to the instruction.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = result;
        wr_tag  = 1'b0;
        trap    = 1'b0;
        trap_pc = pc;
        if (valid) begin
            if (spec) begin
                wr_en = wen;
                if (src_hit) begin
                    wr_data = src_pc;
                    wr_tag  = 1'b1;
                end else if (fault) begin
                    wr_data = pc;
                    wr_tag  = 1'b1;
                end
            end else begin
                if (src_hit) begin
                    trap    = 1'b1;
                    trap_pc = src_pc;
                end else if (fault) begin
                    trap = 1'b1;
                end else begin
                    wr_en = wen;
                end
            end
        end
    end

    always_comb begin
        AST_TRAP_NOT_SPEC: assert (!(trap && spec)); // R4
        AST_TRAP_NO_WRITE: assert (!(trap && wr_en)); // R6
    end
endmodule

// File: rtl/dfr_top.sv
// Module: dfr_top
// Register file with per-register fault tags and deferred exceptions.
// Speculative faults are recorded in the destination. A non-speculative
// reader (the sentinel) turns a recorded fault into a one-cycle trap
// carrying the original faulting PC.
// Assumes at most one instruction completes per cycle and that the
// execution unit raises faults only for memory, divide and FP classes.
module dfr_top #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic              iss_spec,
    input  logic [1:0]        iss_class,
    input  logic [IDX_W-1:0]  iss_rs1,
    input  logic              iss_use1,
    input  logic [IDX_W-1:0]  iss_rs2,
    input  logic              iss_use2,
    input  logic [IDX_W-1:0]  iss_rd,
    input  logic              iss_wen,
    input  logic [DATA_W-1:0] iss_pc,
    input  logic [DATA_W-1:0] iss_result,
    input  logic              iss_fault,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_tag,
    output logic [DATA_W-1:0] rd2_data,
    output logic              rd2_tag,
    output logic              trap_valid,
    output logic [DATA_W-1:0] trap_pc
);
    import dfr_pkg::*;

    logic              wr_en, wr_tag, trap_d;
    logic [DATA_W-1:0] wr_data, trap_pc_d;

    dfr_storage #(.NREG(NREG), .DATA_W(DATA_W)) i_storage (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(iss_rd), .wr_data(wr_data), .wr_tag(wr_tag),
        .ra_idx(iss_rs1), .ra_data(rd1_data), .ra_tag(rd1_tag),
        .rb_idx(iss_rs2), .rb_data(rd2_data), .rb_tag(rd2_tag)
    );

    dfr_resolve #(.DATA_W(DATA_W)) i_resolve (
        .valid(iss_valid), .spec(iss_spec), .use1(iss_use1), .use2(iss_use2),
        .wen(iss_wen), .pc(iss_pc), .result(iss_result), .fault(iss_fault),
        .s1_data(rd1_data), .s1_tag(rd1_tag), .s2_data(rd2_data), .s2_tag(rd2_tag),
        .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
        .trap(trap_d), .trap_pc(trap_pc_d)
    );

    // Purpose: register the trap into a one-cycle pulse with its PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_pc    <= '0;
        end else begin
            trap_valid <= trap_d;
            if (trap_d) trap_pc <= trap_pc_d;
        end
    end

    AST_FAULT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_fault) |-> (op_class_e'(iss_class) != OPC_ALU)); // R8

    AST_TRAP_FROM_NONSPEC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> $past(iss_valid && !iss_spec)); // R10

    AST_TRAP_SKIPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !$past(wr_en)); // R7

    AST_SPEC_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_spec) |=> !trap_valid); // R5
endmodule

// File: tb/test_dfr_top.sv
module test_dfr_top;
    localparam int NREG = 32;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 0, iss_spec = 0, iss_use1 = 0, iss_use2 = 0;
    logic          iss_wen = 0, iss_fault = 0;
    logic [1:0]    iss_class = 0;
    logic [4:0]    iss_rs1 = 0, iss_rs2 = 0, iss_rd = 0;
    logic [DW-1:0] iss_pc = 0, iss_result = 0;
    logic [DW-1:0] rd1_data, rd2_data, trap_pc;
    logic          rd1_tag, rd2_tag, trap_valid;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] m_data [NREG];
    logic          m_tag  [NREG];
    logic [DW-1:0] exp_q [$];

    always #10 clk = ~clk;  // 50 MHz

    dfr_top i_dfr_top (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_spec(iss_spec),
        .iss_class(iss_class), .iss_rs1(iss_rs1), .iss_use1(iss_use1),
        .iss_rs2(iss_rs2), .iss_use2(iss_use2), .iss_rd(iss_rd), .iss_wen(iss_wen),
        .iss_pc(iss_pc), .iss_result(iss_result), .iss_fault(iss_fault),
        .rd1_data(rd1_data), .rd1_tag(rd1_tag), .rd2_data(rd2_data), .rd2_tag(rd2_tag),
        .trap_valid(trap_valid), .trap_pc(trap_pc)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: each trap pulse must match the head of the expected queue (R10).
    always @(negedge clk) begin
        if (rst_n && trap_valid) begin
            if (exp_q.size() == 0) chk("R10 unexpected trap", trap_pc, '1);
            else chk("R10 trap pc", trap_pc, exp_q.pop_front());
        end
    end

    // Driver: predicts the outcome from the requirements, then issues.
    task automatic issue(input logic spec, input logic [1:0] cls,
                         input int rs1, input logic u1, input int rs2, input logic u2,
                         input int rd, input logic wen, input logic [DW-1:0] pc,
                         input logic [DW-1:0] res, input logic flt);
        logic hit1, hit2;
        logic [DW-1:0] spc;
        hit1 = u1 && m_tag[rs1];
        hit2 = u2 && m_tag[rs2];
        spc  = hit1 ? m_data[rs1] : m_data[rs2];
        if (spec) begin
            if (wen && rd != 0) begin
                if (hit1 || hit2) begin m_data[rd] = spc; m_tag[rd] = 1; end
                else if (flt)     begin m_data[rd] = pc;  m_tag[rd] = 1; end
                else              begin m_data[rd] = res; m_tag[rd] = 0; end
            end
        end else begin
            if (hit1 || hit2) exp_q.push_back(spc);
            else if (flt) exp_q.push_back(pc);
            else if (wen && rd != 0) begin m_data[rd] = res; m_tag[rd] = 0; end
        end
        @(negedge clk);
        iss_valid = 1; iss_spec = spec; iss_class = cls;
        iss_rs1 = 5'(rs1); iss_use1 = u1; iss_rs2 = 5'(rs2); iss_use2 = u2;
        iss_rd = 5'(rd); iss_wen = wen; iss_pc = pc; iss_result = res; iss_fault = flt;
        @(negedge clk);
        iss_valid = 0; iss_fault = 0;
    endtask

    task automatic readback(input string req, input int idx);
        iss_rs1 = 5'(idx); iss_rs2 = 5'(idx);
        #1;
        chk(req, rd1_data, m_data[idx]);
        chk(req, {31'd0, rd1_tag}, {31'd0, m_tag[idx]});
        chk(req, rd2_data, m_data[idx]);
    endtask

    initial begin
        #2000000;
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin m_data[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 trap_valid", {31'd0, trap_valid}, 0);
        for (int i = 0; i < NREG; i += 7) readback("R1", i);
        // R3: speculative clean write
        issue(1, 0, 0, 0, 0, 0, 1, 1, 32'h10, 32'h11, 0); readback("R3", 1);
        // R4 / R8: speculative memory fault defers
        issue(1, 1, 1, 1, 0, 0, 2, 1, 32'h100, 32'hdead, 1); readback("R4", 2);
        // R5: propagation through a speculative consumer
        issue(1, 0, 2, 1, 1, 1, 3, 1, 32'h104, 32'hbeef, 0); readback("R5", 3);
        // R6 / R8: non-speculative divide fault, rd unchanged
        issue(0, 2, 1, 1, 0, 0, 1, 1, 32'h200, 32'h55, 1); readback("R6", 1);
        // R7: sentinel reports stored PC, rd unchanged
        issue(0, 0, 3, 1, 0, 0, 4, 1, 32'h204, 32'h66, 0); readback("R7", 4);
        // R8: FP fault deferred the same way
        issue(1, 3, 0, 0, 0, 0, 5, 1, 32'h300, 32'h0, 1); readback("R8", 5);
        // R9: both sources tagged, source 1 wins
        issue(0, 0, 5, 1, 3, 1, 6, 1, 32'h400, 32'h1, 0);
        issue(0, 0, 3, 1, 5, 1, 6, 1, 32'h404, 32'h1, 0);
        issue(1, 0, 5, 1, 2, 1, 7, 1, 32'h408, 32'h1, 0); readback("R9", 7);
        // R11: explicit check on clean and tagged registers
        issue(0, 0, 1, 1, 0, 0, 8, 0, 32'h500, 32'h77, 0); readback("R11", 8);
        issue(0, 0, 2, 1, 0, 0, 8, 0, 32'h504, 32'h77, 0); readback("R11", 8);
        // R12: unused tagged source ignored
        issue(1, 0, 1, 1, 2, 0, 9, 1, 32'h600, 32'h99, 0); readback("R12", 9);
        issue(0, 0, 2, 0, 3, 0, 10, 1, 32'h604, 32'haa, 0); readback("R12", 10);
        // R2: writes to register 0 have no effect
        issue(1, 1, 0, 0, 0, 0, 0, 1, 32'h700, 32'h12, 1); readback("R2", 0);
        issue(0, 0, 0, 1, 0, 1, 0, 1, 32'h704, 32'h34, 0); readback("R2", 0);
        // R3: clean speculative overwrite clears a tag
        issue(1, 0, 0, 0, 0, 0, 2, 1, 32'h800, 32'h22, 0); readback("R3", 2);
        // R13: non-speculative clean write clears a tag
        issue(0, 0, 1, 1, 0, 0, 3, 1, 32'h804, 32'h33, 0); readback("R13", 3);
        // R10: back-to-back traps, then pulse falls
        issue(0, 1, 0, 0, 0, 0, 11, 1, 32'h900, 32'h0, 1);
        issue(0, 1, 0, 0, 0, 0, 11, 1, 32'h904, 32'h0, 1);
        @(negedge clk);
        chk("R10 pulse low", {31'd0, trap_valid}, 0);
        chk("R10 queue drained", 32'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule